// File: doc/BRIEF.md
# Triple Timer Register Interface

This block is the register bank for three identical timer channels, and it contains the three channels. A simple request bus with valid, write, byte address and write data reaches every register as a 32-bit word. Registers of the same kind are grouped together. Within a group, the words for channel 0, 1 and 2 follow one another. The channel is therefore the word address modulo three, and the group is the word address divided by three.

Each channel runs a 16-bit counter. The counter can count up or down, can wrap at a programmable interval or at full scale, and can be slowed by a power-of-two prescaler. Three match values raise events. The counter and prescaler advance once per clock. Events collect in a per-channel status register. Reading that register returns its contents and clears it, and writing ones to it clears the selected bits. A status bit that is set in the same cycle as the clear survives the clear. Each channel drives its own interrupt line.

A read returns its data one cycle after the request. The response carries the register contents as they were before that clock edge.

Top module: `tri_timer_regs`

## Requirements
- R1: After reset every counter control word reads 0x21, which leaves the counter stopped. Every other register reads 0, every irq line is low and rsp_valid is low.
- R2: Byte offsets map to groups as follows:
  - 0x00 clock setup
  - 0x0C counter control
  - 0x18 current count
  - 0x24 interval
  - 0x30 match 1, 0x3C match 2, 0x48 match 3
  - 0x54 status
  - 0x60 interrupt enable
  - 0x6C event setup
  - 0x78 event count

  Within a group, channel n sits at the group's offset + 4n.
- R3: Writes keep only the low bits of the data: 6 bits for clock setup, 6 bits for interrupt enable, 3 bits for event setup, and 16 bits for interval and match.
- R4: Counter control bits have these meanings: bit0 stop, bit1 interval mode, bit2 count down, bit3 match enable, bit4 count reset. Writing with bit4 set zeroes the count and the prescaler. Bit4 always reads back 0, and the other low 6 bits are kept.
- R5: The current count group returns the channel's 16-bit count, and writes to it change nothing.
- R6: A read request gets a response one cycle later. Reading a status word returns its value and clears all of its bits.
- R7: Writing a status word clears exactly the bits written as 1.
- R8: A status event raised in the same cycle as a read-clear or write-clear of that word remains set afterwards.
- R9: Reads return 0 and writes are ignored at these places:
  - offsets beyond 0x80
  - addresses whose two low bits are not zero
  - the event count group, which always reads 0
- R10: A write to one match register of a channel leaves that channel's other two match registers unchanged.
- R11: irq[n] is high exactly when status and interrupt enable of channel n share a set bit.
- R12: The counter steps only while bit0 is clear.
  - Counting up, the step after reaching the limit goes to 0. The limit is the interval in interval mode, otherwise 0xFFFF.
  - Counting down, the step from 0 goes to the limit.
  - A wrap sets status bit0 in interval mode, otherwise status bit4.
  - With match enable set, a step that lands on match k (k=1..3) sets status bit k.
- R13: Clock setup bit0 enables the prescaler. Bits 4:1 hold an exponent v, and the counter then steps once every 2^(v+1) cycles. With bit0 clear it steps every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_data | output | 32 | Read data, 0 when rsp_valid is low |
| irq | output | 3 | Per-channel interrupt line |

## Verification
The bench builds the block with the default ADDR_W of 8. With that width, every mapped word can be reached, and so can unmapped offsets up to 0xFC, including misaligned ones. Directed runs use a prescaler exponent of 1 and intervals of 0 to 4. This makes wraps, match hits and events that coincide with a clear happen within a few cycles. A long random phase then mixes every group and channel against the cycle model.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    localparam int NCH     = 3;
    localparam int CH_W    = $clog2(NCH);
    localparam int NGRP    = 11;
    localparam int GRP_W   = 4;
    localparam int NMATCH  = 3;
    localparam int CNT_W   = 16;
    localparam int STS_W   = 6;
    localparam int CLKC_W  = 6;
    localparam int CTL_W   = 6;
    localparam int EVC_W   = 3;
    localparam int DATA_W  = 32;
    localparam int PSV_W   = 4;
    localparam int PC_W    = 2 ** PSV_W;

    // counter control bit positions
    localparam int CTL_OFF  = 0;
    localparam int CTL_ITV  = 1;
    localparam int CTL_DOWN = 2;
    localparam int CTL_MEN  = 3;
    localparam int CTL_CLR  = 4;
    localparam logic [CTL_W-1:0] CTL_RST = 6'h21;

    // status bit positions
    localparam int ST_ITV = 0;
    localparam int ST_M0  = 1;
    localparam int ST_OVF = 4;

    typedef enum logic [GRP_W-1:0] {
        G_CLK  = 4'd0,
        G_CTL  = 4'd1,
        G_CNT  = 4'd2,
        G_ITV  = 4'd3,
        G_M1   = 4'd4,
        G_M2   = 4'd5,
        G_M3   = 4'd6,
        G_STS  = 4'd7,
        G_IEN  = 4'd8,
        G_EVC  = 4'd9,
        G_EVN  = 4'd10,
        G_NONE = 4'd15
    } grp_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  pc;
    } chan_t;

    typedef struct packed {
        logic [NCH-1:0][CLKC_W-1:0]             clkc;
        logic [NCH-1:0][CTL_W-1:0]              ctl;
        logic [NCH-1:0][CNT_W-1:0]              itv;
        logic [NCH-1:0][NMATCH-1:0][CNT_W-1:0]  mt;
        logic [NCH-1:0][STS_W-1:0]              sts;
        logic [NCH-1:0][STS_W-1:0]              ien;
        logic [NCH-1:0][EVC_W-1:0]              evc;
        logic                                   rsp_v;
        logic [DATA_W-1:0]                      rsp_d;
    } regs_t;
endpackage

// File: rtl/ttc_addr_dec.sv
module ttc_addr_dec
    import ttc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output grp_e              grp_o,
    output logic [CH_W-1:0]   ch_o
);
    int unsigned word;

    always_comb begin
        word  = 32'(addr_i[ADDR_W-1:2]);
        grp_o = G_NONE;
        ch_o  = '0;
        if (addr_i[1:0] == 2'b00 && word < NCH * NGRP) begin
            grp_o = grp_e'(GRP_W'(word / NCH));
            ch_o  = CH_W'(word % NCH);
        end
    end
endmodule

// File: rtl/ttc_chan.sv
module ttc_chan
    import ttc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [PSV_W:0]                 clkc_i,
    input  logic [CTL_MEN:0]               ctl_i,
    input  logic [CNT_W-1:0]               itv_i,
    input  logic [NMATCH-1:0][CNT_W-1:0]   mt_i,
    input  logic                           clr_i,
    output logic [CNT_W-1:0]               cnt_o,
    output logic [STS_W-1:0]               evt_o
);
    chan_t            chan_q, chan_d;
    logic             step, wrap;
    logic [CNT_W-1:0] lim;
    logic [PC_W:0]    pc_top;

    always_comb begin
        chan_d = chan_q;
        evt_o  = '0;
        step   = 1'b0;
        wrap   = 1'b0;
        lim    = ctl_i[CTL_ITV] ? itv_i : '1;
        pc_top = ((PC_W+1)'(2) << clkc_i[PSV_W:1]) - (PC_W+1)'(1);
        if (clr_i) begin
            chan_d.cnt = '0;
            chan_d.pc  = '0;
        end else if (!ctl_i[CTL_OFF]) begin
            if (clkc_i[0]) begin
                if ({1'b0, chan_q.pc} == pc_top) begin
                    chan_d.pc = '0;
                    step      = 1'b1;
                end else begin
                    chan_d.pc = chan_q.pc + 1'b1;
                end
            end else begin
                chan_d.pc = '0;
                step      = 1'b1;
            end
            if (step) begin
                if (ctl_i[CTL_DOWN]) begin
                    if (chan_q.cnt == '0) begin
                        chan_d.cnt = lim;
                        wrap       = 1'b1;
                    end else begin
                        chan_d.cnt = chan_q.cnt - 1'b1;
                    end
                end else if (chan_q.cnt >= lim) begin
                    chan_d.cnt = '0;
                    wrap       = 1'b1;
                end else begin
                    chan_d.cnt = chan_q.cnt + 1'b1;
                end
                if (wrap) begin
                    if (ctl_i[CTL_ITV]) evt_o[ST_ITV] = 1'b1;
                    else                evt_o[ST_OVF] = 1'b1;
                end
                for (int i = 0; i < NMATCH; i++) begin
                    if (ctl_i[CTL_MEN] && chan_d.cnt == mt_i[i]) evt_o[ST_M0+i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign cnt_o = chan_q.cnt;
endmodule

// File: rtl/tri_timer_regs.sv
module tri_timer_regs
    import ttc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic [NCH-1:0]    irq
);
    regs_t                        state_q, state_d;
    grp_e                         dec_grp;
    logic [CH_W-1:0]              dec_ch;
    logic [NCH-1:0][CNT_W-1:0]    cnt;
    logic [NCH-1:0][STS_W-1:0]    evt;
    logic [NCH-1:0]               cnt_clr;
    logic [DATA_W-1:0]            rdata;
    logic                         rd_req, wr_req;
    logic                         unused_wdata;

    assign rd_req       = req_valid && !req_write;
    assign wr_req       = req_valid && req_write;
    assign unused_wdata = ^req_wdata[31:CNT_W];

    ttc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (req_addr),
        .grp_o  (dec_grp),
        .ch_o   (dec_ch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ttc_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .clkc_i (state_q.clkc[c][PSV_W:0]),
            .ctl_i  (state_q.ctl[c][CTL_MEN:0]),
            .itv_i  (state_q.itv[c]),
            .mt_i   (state_q.mt[c]),
            .clr_i  (cnt_clr[c]),
            .cnt_o  (cnt[c]),
            .evt_o  (evt[c])
        );
        assign irq[c] = |(state_q.sts[c] & state_q.ien[c]);
    end

    // read data mux
    always_comb begin
        rdata = '0;
        case (dec_grp)
            G_CLK: rdata = DATA_W'(state_q.clkc[dec_ch]);
            G_CTL: rdata = DATA_W'(state_q.ctl[dec_ch]);
            G_CNT: rdata = DATA_W'(cnt[dec_ch]);
            G_ITV: rdata = DATA_W'(state_q.itv[dec_ch]);
            G_M1:  rdata = DATA_W'(state_q.mt[dec_ch][0]);
            G_M2:  rdata = DATA_W'(state_q.mt[dec_ch][1]);
            G_M3:  rdata = DATA_W'(state_q.mt[dec_ch][2]);
            G_STS: rdata = DATA_W'(state_q.sts[dec_ch]);
            G_IEN: rdata = DATA_W'(state_q.ien[dec_ch]);
            G_EVC: rdata = DATA_W'(state_q.evc[dec_ch]);
            default: rdata = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        logic [STS_W-1:0] clr_mask;
        state_d       = state_q;
        cnt_clr       = '0;
        state_d.rsp_v = rd_req;
        state_d.rsp_d = rd_req ? rdata : '0;

        for (int c = 0; c < NCH; c++) begin
            clr_mask = '0;
            if (req_valid && dec_grp == G_STS && dec_ch == CH_W'(c)) begin
                clr_mask = req_write ? req_wdata[STS_W-1:0] : '1;
            end
            state_d.sts[c] = (state_q.sts[c] & ~clr_mask) | evt[c];
        end

        if (wr_req) begin
            case (dec_grp)
                G_CLK: state_d.clkc[dec_ch] = req_wdata[CLKC_W-1:0];
                G_CTL: begin
                    state_d.ctl[dec_ch]          = req_wdata[CTL_W-1:0];
                    state_d.ctl[dec_ch][CTL_CLR] = 1'b0;
                    cnt_clr[dec_ch]              = req_wdata[CTL_CLR];
                end
                G_ITV: state_d.itv[dec_ch]   = req_wdata[CNT_W-1:0];
                G_M1:  state_d.mt[dec_ch][0] = req_wdata[CNT_W-1:0];
                G_M2:  state_d.mt[dec_ch][1] = req_wdata[CNT_W-1:0];
                G_M3:  state_d.mt[dec_ch][2] = req_wdata[CNT_W-1:0];
                G_IEN: state_d.ien[dec_ch]   = req_wdata[STS_W-1:0];
                G_EVC: state_d.evc[dec_ch]   = req_wdata[EVC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            for (int c = 0; c < NCH; c++) state_q.ctl[c] <= CTL_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_v;
    assign rsp_data  = state_q.rsp_d;
endmodule

// File: rtl/tri_timer_regs_chk.sv
module tri_timer_regs_chk
    import ttc_pkg::*;
(
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  req_valid,
    input logic                                  req_write,
    input logic                                  clr_bit,
    input grp_e                                  dec_grp,
    input logic [CH_W-1:0]                       dec_ch,
    input logic                                  rsp_valid,
    input logic [NCH-1:0][STS_W-1:0]             sts,
    input logic [NCH-1:0][STS_W-1:0]             evt,
    input logic [NCH-1:0][CNT_W-1:0]             cnt,
    input logic [NCH-1:0][NMATCH-1:0][CNT_W-1:0] mt
);
    logic rd, wr;
    assign rd = req_valid && !req_write;
    assign wr = req_valid && req_write;

    AST_RSP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) rd |=> rsp_valid); // R6
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd |=> !rsp_valid); // R6
    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) (wr && dec_grp == G_NONE) |=> $stable(mt)); // R9

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic hit;
        assign hit = (dec_ch == CH_W'(c));

        AST_STS_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd && dec_grp == G_STS && hit && evt[c] == '0) |=> sts[c] == '0); // R6
        AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n) (evt[c] != '0) |=> ((sts[c] & $past(evt[c])) == $past(evt[c]))); // R8
        AST_CNT_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n) (wr && dec_grp == G_CTL && hit && clr_bit) |=> cnt[c] == '0); // R4
        AST_M1_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) (wr && dec_grp == G_M1 && hit) |=> ($stable(mt[c][1]) && $stable(mt[c][2]))); // R10
        AST_M2_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) (wr && dec_grp == G_M2 && hit) |=> ($stable(mt[c][0]) && $stable(mt[c][2]))); // R10
        AST_M3_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) (wr && dec_grp == G_M3 && hit) |=> ($stable(mt[c][0]) && $stable(mt[c][1]))); // R10
    end
endmodule

bind tri_timer_regs tri_timer_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .clr_bit   (req_wdata[ttc_pkg::CTL_CLR]),
    .dec_grp   (dec_grp),
    .dec_ch    (dec_ch),
    .rsp_valid (rsp_valid),
    .sts       (state_q.sts),
    .evt       (evt),
    .cnt       (cnt),
    .mt        (state_q.mt)
);

// File: tb/tb_tri_timer_regs.sv
module tb_tri_timer_regs;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [31:0]       req_wdata;
    logic              rsp_valid;
    logic [31:0]       rsp_data;
    logic [2:0]        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_clkc[3], m_ctl[3], m_cnt[3], m_pc[3], m_itv[3], m_sts[3], m_ien[3], m_evc[3];
    int m_mt[3][3];
    int e_rsp_v, e_rsp_d, e_irq;

    tri_timer_regs #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int grp_of(int a);
        int w = a >> 2;
        if ((a & 3) != 0 || w >= 33) return -1;
        return w / 3;
    endfunction

    function automatic int rd_val(int g, int c);
        case (g)
            0: return m_clkc[c];
            1: return m_ctl[c];
            2: return m_cnt[c];
            3: return m_itv[c];
            4, 5, 6: return m_mt[c][g-4];
            7: return m_sts[c];
            8: return m_ien[c];
            9: return m_evc[c];
            default: return 0;
        endcase
    endfunction

    task automatic model_step(bit v, bit w, int a, int d);
        int g = grp_of(a);
        int c = (a >> 2) % 3;
        int nc[3], npc[3], nst[3];
        e_rsp_v = (v && !w) ? 1 : 0;
        e_rsp_d = (v && !w) ? rd_val(g, c) : 0;
        for (int ch = 0; ch < 3; ch++) begin
            int ev = 0, clrm = 0;
            nc[ch] = m_cnt[ch]; npc[ch] = m_pc[ch];
            if (v && w && g == 1 && c == ch && (d & 16) != 0) begin
                nc[ch] = 0; npc[ch] = 0;
            end else if ((m_ctl[ch] & 1) == 0) begin
                bit step = 0;
                if ((m_clkc[ch] & 1) != 0) begin
                    int top = (2 << ((m_clkc[ch] >> 1) & 15)) - 1;
                    if (m_pc[ch] == top) begin npc[ch] = 0; step = 1; end
                    else npc[ch] = m_pc[ch] + 1;
                end else begin
                    npc[ch] = 0; step = 1;
                end
                if (step) begin
                    int lim = ((m_ctl[ch] & 2) != 0) ? m_itv[ch] : 65535;
                    bit wrap = 0;
                    if ((m_ctl[ch] & 4) != 0) begin
                        if (m_cnt[ch] == 0) begin nc[ch] = lim; wrap = 1; end
                        else nc[ch] = m_cnt[ch] - 1;
                    end else if (m_cnt[ch] >= lim) begin
                        nc[ch] = 0; wrap = 1;
                    end else nc[ch] = m_cnt[ch] + 1;
                    if (wrap) ev |= ((m_ctl[ch] & 2) != 0) ? 1 : 16;
                    if ((m_ctl[ch] & 8) != 0)
                        for (int i = 0; i < 3; i++) if (nc[ch] == m_mt[ch][i]) ev |= (2 << i);
                end
            end
            if (v && g == 7 && c == ch) clrm = w ? (d & 63) : 63;
            nst[ch] = (m_sts[ch] & ~clrm) | ev;
        end
        if (v && w) begin
            case (g)
                0: m_clkc[c] = d & 63;
                1: m_ctl[c]  = d & 47;
                3: m_itv[c]  = d & 65535;
                4, 5, 6: m_mt[c][g-4] = d & 65535;
                8: m_ien[c]  = d & 63;
                9: m_evc[c]  = d & 7;
                default: ;
            endcase
        end
        e_irq = 0;
        for (int ch = 0; ch < 3; ch++) begin
            m_cnt[ch] = nc[ch]; m_pc[ch] = npc[ch]; m_sts[ch] = nst[ch];
            if ((m_sts[ch] & m_ien[ch]) != 0) e_irq |= (1 << ch);
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic cycle(bit v, bit w, int a, int d);
        req_valid = v; req_write = w; req_addr = ADDR_W'(a); req_wdata = d;
        model_step(v, w, a, d);
        @(negedge clk);
        chk({cur_req, " rsp_valid"}, rsp_valid, e_rsp_v);
        chk({cur_req, " rsp_data"}, rsp_data, e_rsp_d);
        chk({cur_req, " irq"}, irq, e_irq);
    endtask

    task automatic wr(int a, int d); cycle(1, 1, a, d); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) cycle(0, 0, 0, 0); endtask
    task automatic rd_chk(string req, int a, int exp);
        cycle(1, 0, a, 0);
        chk({req, " read value"}, rsp_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        for (int c = 0; c < 3; c++) begin
            m_clkc[c] = 0; m_ctl[c] = 'h21; m_cnt[c] = 0; m_pc[c] = 0; m_itv[c] = 0;
            m_sts[c] = 0; m_ien[c] = 0; m_evc[c] = 0;
            for (int i = 0; i < 3; i++) m_mt[c][i] = 0;
        end
        e_rsp_v = 0; e_rsp_d = 0; e_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        cur_req = "R1";
        chk("R1 irq after reset", irq, 0);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        rd_chk("R1", 'h0C, 'h21);
        rd_chk("R1", 'h14, 'h21);
        rd_chk("R1", 'h00, 0);
        rd_chk("R1", 'h18, 0);
        for (int a = 0; a <= 'h80; a += 4) cycle(1, 0, a, 0);

        // R3 write masks (channel 1)
        cur_req = "R3";
        wr('h04, 32'hFFFF_FFFF); rd_chk("R3", 'h04, 'h3F);
        wr('h64, 32'hFFFF_FFFF); rd_chk("R3", 'h64, 'h3F);
        wr('h70, 32'hFFFF_FFFF); rd_chk("R3", 'h70, 'h7);
        wr('h28, 32'hFFFF_FFFF); rd_chk("R3", 'h28, 'hFFFF);

        // R2 channel interleave
        cur_req = "R2";
        wr('h24, 'h11); wr('h28, 'h22); wr('h2C, 'h33);
        rd_chk("R2", 'h24, 'h11); rd_chk("R2", 'h28, 'h22); rd_chk("R2", 'h2C, 'h33);

        // R10 match isolation
        cur_req = "R10";
        wr('h30, 'hAAAA); wr('h3C, 'hBBBB); wr('h48, 'hCCCC); wr('h30, 'h1234);
        rd_chk("R10", 'h3C, 'hBBBB); rd_chk("R10", 'h48, 'hCCCC); rd_chk("R10", 'h30, 'h1234);

        // R9 unmapped and misaligned
        cur_req = "R9";
        wr('h84, 'hFFFF); wr('h25, 'h77); wr('hFC, 'h5);
        rd_chk("R9", 'h84, 0); rd_chk("R9", 'h25, 0); rd_chk("R9", 'h78, 0);
        rd_chk("R9", 'h24, 'h11);

        // R5 count is read-only
        cur_req = "R5";
        wr('h18, 'h55); rd_chk("R5", 'h18, 0);

        // R12 up count, interval 4, match1 = 2 on channel 0
        cur_req = "R12";
        wr('h24, 4); wr('h30, 2); wr('h3C, 'h100); wr('h48, 'h100);
        wr('h0C, 'h0A); idle(8); wr('h0C, 'h0B);
        rd_chk("R12", 'h18, 4);
        rd_chk("R12", 'h54, 'h03);
        rd_chk("R6", 'h54, 'h00);

        // R4 count reset command
        cur_req = "R4";
        wr('h0C, 'h1B);
        rd_chk("R4", 'h18, 0); rd_chk("R4", 'h0C, 'h0B);

        // R13 prescaler on channel 1 (divide by 4)
        cur_req = "R13";
        wr('h04, 'h03); wr('h10, 'h00); idle(40); wr('h10, 'h01);
        rd_chk("R13", 'h1C, 10);

        // R12 down count, interval 3 on channel 2
        cur_req = "R12";
        wr('h2C, 3); wr('h14, 'h06); idle(6); wr('h14, 'h07);
        rd_chk("R12", 'h20, 1);
        rd_chk("R12", 'h5C, 'h01);

        // R8 event in the same cycle as a read-clear
        cur_req = "R8";
        wr('h24, 0); wr('h0C, 'h02); idle(2);
        rd_chk("R6", 'h54, 1);
        rd_chk("R8", 'h54, 1);

        // R11 and R7
        cur_req = "R11";
        wr('h30, 0); wr('h0C, 'h0A); idle(1); wr('h0C, 'h0B);
        wr('h60, 'h04); chk("R11 irq0 masked", irq[0], 0);
        wr('h60, 'h02); chk("R11 irq0 enabled", irq[0], 1);
        cur_req = "R7";
        wr('h54, 'h01);
        rd_chk("R7", 'h54, 'h02);
        chk("R6 irq0 after clear-on-read", irq[0], 0);

        // mixed random traffic against the model
        cur_req = "R2 random";
        for (int k = 0; k < 4000; k++) begin
            int a = ($urandom % 36) * 4;
            int d = $urandom;
            if ($urandom % 8 == 0) a = a + 1;
            if ($urandom % 2 == 0) d = d & 'h1F;
            if ($urandom % 2 == 0) a = 'h0C + 4 * ($urandom % 3);
            cycle($urandom % 3 != 0, $urandom % 2, a, d);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule